// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One 16-bit down-counting channel of an interval timer, used to make a periodic system tick or a single delayed event. Software moves the count through one 8-bit port. A write to the port loads a byte of the initial count. A read returns a byte of the current count, or of a latched snapshot of it. A separate command strobe on the same data bus either takes a snapshot of the count or selects the operating mode. The count moves down by one on each cycle where the count-enable strobe is high. That strobe is produced elsewhere from a fixed timer reference of about 1.19318 MHz.

Three operating modes are supported. In the one-shot mode, the output level rises once the loaded count has run out. In the two periodic modes, the channel reloads itself and raises a one-cycle interrupt pulse each time it expires. A command that asks for an unsupported mode, access pattern or decimal counting sets a sticky error flag and changes nothing else.

Top module: `pit_channel`

## Requirements
- R1: Synchronous active-high reset clears the output level, the interrupt, the error flag and the data output, and leaves the counter inactive so the count reads as zero. It sets both byte toggles to the low byte, drops any pending latch and selects the one-shot mode.
- R2: The initial count is written low byte first, then high byte. A low-byte write stops the countdown and drives the output level low. Counting restarts only on the high-byte write. A byte write in the same cycle as a count strobe takes precedence, so that strobe is lost.
- R3: In the periodic modes (mode field 2 or 3), the effective period is the loaded count minus one. When a strobe arrives with one count remaining, the counter reloads the period and keeps running. A live read returns the remaining count plus one.
- R4: In the one-shot mode (mode field 0), the period is the full loaded count. At expiry the output level goes high and stays high until the next low-byte write. The counter then becomes inactive, reads as zero and raises no further interrupts.
- R5: If the effective period is zero, no countdown starts. The count reads zero and no interrupt follows.
- R6: Every expiry raises `irq` for exactly one cycle, in the cycle after the clock edge at which the final strobe was taken.
- R7: A command whose access field (bits 5:4) is 00 snapshots the current count if no snapshot is pending, and resets the read toggle to the low byte. Further such commands are ignored until the snapshot's high byte has been read.
- R8: Reads return the low byte and then the high byte, from the snapshot while one is pending and from the live count otherwise. `dout` is registered and is valid in the cycle after the read strobe.
- R9: The command byte is laid out as follows: bits 5:4 access (00 latch, 11 low-then-high), bits 3:1 mode, bit 0 decimal flag. Bits 7:6 are ignored.
- R10: A command with access 01 or 10, a mode other than 0, 2 or 3, or the decimal flag set raises `cfg_err`. The flag stays set until reset, and the previous mode remains in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count strobe from the timer reference |
| wr_stb | input | 1 | Write one count byte from `din` |
| rd_stb | input | 1 | Read one count byte into `dout` |
| cmd_stb | input | 1 | Treat `din` as a command byte |
| din | input | 8 | Data or command byte |
| dout | output | 8 | Registered read data |
| out_level | output | 1 | Channel output level |
| irq | output | 1 | One-cycle expiry pulse |
| cfg_err | output | 1 | Sticky unsupported-command flag |

## Verification
A wrong byte toggle shows up on the next write or read: a count lands in the wrong half, or the bytes come back swapped. A stuck latch shows on the pair of reads after it, which return stale data where the live count was expected. An off-by-one period or a wrong mode decode changes the number of strobes between `irq` pulses, and that is visible at the first expiry. An illegal command that is wrongly adopted changes the interrupt count within one period.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    MD_ONESHOT = 2'd0,
    MD_RATE    = 2'd1,
    MD_SQUARE  = 2'd2
  } pit_mode_e;

  localparam logic [1:0] ACC_LATCH  = 2'b00;
  localparam logic [1:0] ACC_LO_HI  = 2'b11;
  localparam logic [2:0] MF_ONESHOT = 3'd0;
  localparam logic [2:0] MF_RATE    = 3'd2;
  localparam logic [2:0] MF_SQUARE  = 3'd3;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_stb,
  input  logic [5:0] cmd,
  output logic       latch_req,
  output pit_mode_e  mode_q,
  output logic       cfg_err
);
  logic [1:0] acc;
  logic [2:0] mf;
  logic       dec;
  logic       prog;
  logic       legal;
  pit_mode_e  mode_d;

  assign acc = cmd[5:4];
  assign mf  = cmd[3:1];
  assign dec = cmd[0];

  assign latch_req = cmd_stb && (acc == ACC_LATCH);
  assign prog      = cmd_stb && (acc != ACC_LATCH);

  always_comb begin
    legal  = (acc == ACC_LO_HI) && !dec;
    mode_d = mode_q;
    case (mf)
      MF_ONESHOT: mode_d = MD_ONESHOT;
      MF_RATE:    mode_d = MD_RATE;
      MF_SQUARE:  mode_d = MD_SQUARE;
      default:    legal  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_ONESHOT;
      cfg_err <= 1'b0;
    end else if (prog) begin
      if (legal) mode_q <= mode_d;
      else       cfg_err <= 1'b1;
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  pit_mode_e         mode,
  input  logic              cnt_en,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] din,
  output logic              out_level,
  output logic              irq,
  output logic              wr_hi,
  output logic [CNT_W-1:0]  cur_count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [BYTE_W-1:0] init_lo;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  remain;
  logic              active;
  logic              periodic;
  logic [CNT_W-1:0]  full;
  logic [CNT_W-1:0]  eff;

  assign periodic = (mode != MD_ONESHOT);
  assign full     = {din, init_lo};
  assign eff      = periodic ? full - ONE : full;

  always_comb begin
    if (!active)       cur_count = '0;
    else if (periodic) cur_count = remain + ONE;
    else               cur_count = remain;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_lo   <= '0;
      period    <= '0;
      remain    <= '0;
      active    <= 1'b0;
      out_level <= 1'b0;
      irq       <= 1'b0;
      wr_hi     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_stb) begin
        if (!wr_hi) begin
          init_lo   <= din;
          active    <= 1'b0;
          out_level <= 1'b0;
          wr_hi     <= 1'b1;
        end else begin
          wr_hi <= 1'b0;
          if (eff != '0) begin
            period <= eff;
            remain <= eff;
            active <= 1'b1;
          end
        end
      end else if (cnt_en && active) begin
        if (remain == ONE) begin
          irq <= 1'b1;
          if (periodic) begin
            remain <= period;
          end else begin
            out_level <= 1'b1;
            active    <= 1'b0;
          end
        end else begin
          remain <= remain - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pit_readout.sv
module pit_readout #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_req,
  input  logic              rd_stb,
  input  logic [CNT_W-1:0]  cur_count,
  output logic [BYTE_W-1:0] dout,
  output logic              latch_on,
  output logic [CNT_W-1:0]  latch_val
);
  logic             rd_hi;
  logic [CNT_W-1:0] src;

  assign src = latch_on ? latch_val : cur_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= '0;
      latch_on  <= 1'b0;
      latch_val <= '0;
      rd_hi     <= 1'b0;
    end else if (latch_req && !latch_on) begin
      latch_on  <= 1'b1;
      latch_val <= cur_count;
      rd_hi     <= 1'b0;
    end else if (rd_stb) begin
      dout  <= rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
      rd_hi <= ~rd_hi;
      if (latch_on && rd_hi) latch_on <= 1'b0;
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              cmd_stb,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              out_level,
  output logic              irq,
  output logic              cfg_err
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             latch_req;
  pit_mode_e        mode_q;
  logic             wr_hi;
  logic [CNT_W-1:0] cur_count;
  logic             latch_on;
  logic [CNT_W-1:0] latch_val;

  pit_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_stb   (cmd_stb),
    .cmd       (din[5:0]),
    .latch_req (latch_req),
    .mode_q    (mode_q),
    .cfg_err   (cfg_err)
  );

  pit_counter #(.BYTE_W(BYTE_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .cnt_en    (cnt_en),
    .wr_stb    (wr_stb),
    .din       (din),
    .out_level (out_level),
    .irq       (irq),
    .wr_hi     (wr_hi),
    .cur_count (cur_count)
  );

  pit_readout #(.BYTE_W(BYTE_W)) u_readout (
    .clk       (clk),
    .rst       (rst),
    .latch_req (latch_req),
    .rd_stb    (rd_stb),
    .cur_count (cur_count),
    .dout      (dout),
    .latch_on  (latch_on),
    .latch_val (latch_val)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic             irq,
  input logic             out_level,
  input logic             cfg_err,
  input logic             wr_hi,
  input logic             latch_on,
  input logic [CNT_W-1:0] latch_val
);
  assert_irq_follows_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(cnt_en));

  assert_lowbyte_stops_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_hi) |=> (!out_level && !irq));

  assert_out_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (out_level && !(wr_stb && !wr_hi)) |=> out_level);

  assert_out_rises_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_level) |-> $past(cnt_en));

  assert_snapshot_held_R7: assert property (@(posedge clk) disable iff (rst)
    (latch_on && !rd_stb) |=> $stable(latch_val));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

bind pit_channel pit_channel_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en    (cnt_en),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .irq       (irq),
  .out_level (out_level),
  .cfg_err   (cfg_err),
  .wr_hi     (wr_hi),
  .latch_on  (latch_on),
  .latch_val (latch_val)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
  localparam logic [3:0] OP_CMD  = 4'd0;
  localparam logic [3:0] OP_WR   = 4'd1;
  localparam logic [3:0] OP_RD   = 4'd2;
  localparam logic [3:0] OP_TICK = 4'd3;
  localparam logic [3:0] OP_OUT  = 4'd4;
  localparam logic [3:0] OP_IRQ  = 4'd5;
  localparam logic [3:0] OP_ERR  = 4'd6;
  localparam int NV = 66;

  // {op, argument, expected, requirement number}
  localparam logic [23:0] VEC [NV] = '{
    {OP_CMD, 8'h34, 8'h00, 4'd3},   // R3 rate mode
    {OP_WR,  8'h05, 8'h00, 4'd2},   // R2 low byte
    {OP_WR,  8'h00, 8'h00, 4'd2},   // R2 high byte, period 4
    {OP_RD,  8'h00, 8'h05, 4'd3},   // R3 live = remain+1
    {OP_RD,  8'h00, 8'h00, 4'd8},   // R8 high byte
    {OP_TICK,8'd1,  8'h00, 4'd3},
    {OP_RD,  8'h00, 8'h04, 4'd3},
    {OP_RD,  8'h00, 8'h00, 4'd8},
    {OP_IRQ, 8'h00, 8'd0,  4'd3},
    {OP_TICK,8'd3,  8'h00, 4'd3},   // fires on third strobe
    {OP_IRQ, 8'h00, 8'd1,  4'd6},   // R6
    {OP_RD,  8'h00, 8'h05, 4'd3},   // reloaded
    {OP_RD,  8'h00, 8'h00, 4'd8},
    {OP_TICK,8'd4,  8'h00, 4'd3},
    {OP_IRQ, 8'h00, 8'd2,  4'd3},   // R3 period 4
    {OP_CMD, 8'h00, 8'h00, 4'd7},   // R7 latch 5
    {OP_TICK,8'd2,  8'h00, 4'd7},
    {OP_CMD, 8'h00, 8'h00, 4'd7},   // R7 ignored
    {OP_RD,  8'h00, 8'h05, 4'd7},
    {OP_RD,  8'h00, 8'h00, 4'd7},   // releases
    {OP_RD,  8'h00, 8'h03, 4'd8},   // R8 live again
    {OP_RD,  8'h00, 8'h00, 4'd8},
    {OP_CMD, 8'h30, 8'h00, 4'd4},   // R4 one-shot
    {OP_WR,  8'h03, 8'h00, 4'd2},
    {OP_OUT, 8'h00, 8'd0,  4'd2},
    {OP_TICK,8'd2,  8'h00, 4'd2},   // stopped: no count
    {OP_IRQ, 8'h00, 8'd2,  4'd2},   // R2
    {OP_WR,  8'h00, 8'h00, 4'd4},
    {OP_RD,  8'h00, 8'h03, 4'd4},
    {OP_RD,  8'h00, 8'h00, 4'd4},
    {OP_TICK,8'd2,  8'h00, 4'd4},
    {OP_OUT, 8'h00, 8'd0,  4'd4},
    {OP_RD,  8'h00, 8'h01, 4'd4},
    {OP_RD,  8'h00, 8'h00, 4'd4},
    {OP_TICK,8'd1,  8'h00, 4'd4},
    {OP_OUT, 8'h00, 8'd1,  4'd4},   // R4 expiry
    {OP_IRQ, 8'h00, 8'd3,  4'd4},
    {OP_RD,  8'h00, 8'h00, 4'd4},   // inactive reads 0
    {OP_RD,  8'h00, 8'h00, 4'd4},
    {OP_TICK,8'd5,  8'h00, 4'd4},
    {OP_IRQ, 8'h00, 8'd3,  4'd4},
    {OP_OUT, 8'h00, 8'd1,  4'd4},
    {OP_WR,  8'h07, 8'h00, 4'd4},
    {OP_OUT, 8'h00, 8'd0,  4'd4},   // cleared by low byte
    {OP_WR,  8'h00, 8'h00, 4'd4},
    {OP_CMD, 8'h34, 8'h00, 4'd5},
    {OP_WR,  8'h01, 8'h00, 4'd5},
    {OP_WR,  8'h00, 8'h00, 4'd5},   // R5 period 0
    {OP_RD,  8'h00, 8'h00, 4'd5},
    {OP_RD,  8'h00, 8'h00, 4'd5},
    {OP_TICK,8'd3,  8'h00, 4'd5},
    {OP_IRQ, 8'h00, 8'd3,  4'd5},
    {OP_ERR, 8'h00, 8'd0,  4'd10},
    {OP_CMD, 8'h31, 8'h00, 4'd10},  // R10 decimal flag
    {OP_ERR, 8'h00, 8'd1,  4'd10},
    {OP_CMD, 8'h12, 8'h00, 4'd10},  // bad access
    {OP_CMD, 8'h32, 8'h00, 4'd10},  // bad mode
    {OP_WR,  8'h03, 8'h00, 4'd10},
    {OP_WR,  8'h00, 8'h00, 4'd10},
    {OP_TICK,8'd2,  8'h00, 4'd10},
    {OP_IRQ, 8'h00, 8'd4,  4'd10},  // R10 still rate mode
    {OP_CMD, 8'hF6, 8'h00, 4'd9},   // R9 square, top bits ignored
    {OP_WR,  8'h02, 8'h00, 4'd9},
    {OP_WR,  8'h00, 8'h00, 4'd9},
    {OP_TICK,8'd3,  8'h00, 4'd9},
    {OP_IRQ, 8'h00, 8'd7,  4'd9}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       wr_stb = 1'b0;
  logic       rd_stb = 1'b0;
  logic       cmd_stb = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       out_level;
  logic       irq;
  logic       cfg_err;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;

  always #10 clk = ~clk;

  pit_channel u_pit_channel (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .cmd_stb(cmd_stb), .din(din), .dout(dout), .out_level(out_level),
    .irq(irq), .cfg_err(cfg_err)
  );

  always @(negedge clk) if (!rst && irq === 1'b1) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk); din = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] d);
    @(negedge clk); din = d; cmd_stb = 1'b1;
    @(negedge clk); cmd_stb = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] v);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; v = dout;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1;
      @(negedge clk); cnt_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dout", dout, 0);
    chk("R1 out", out_level, 0);
    chk("R1 irq", irq, 0);
    chk("R1 err", cfg_err, 0);
    do_rd(v); chk("R1 read lo", v, 0);
    do_rd(v); chk("R1 read hi", v, 0);

    for (int k = 0; k < NV; k++) begin
      logic [3:0] op;
      logic [7:0] a, e;
      op = VEC[k][23:20]; a = VEC[k][19:12]; e = VEC[k][11:4];
      tag = $sformatf("R%0d vec%0d", VEC[k][3:0], k);
      case (op)
        OP_CMD:  do_cmd(a);
        OP_WR:   do_wr(a);
        OP_RD:   begin do_rd(v); chk(tag, v, e); end
        OP_TICK: do_tick(a);
        OP_OUT:  chk(tag, out_level, e);
        OP_IRQ:  begin @(negedge clk); chk(tag, irq_cnt, e); end
        OP_ERR:  chk(tag, cfg_err, e);
        default: ;
      endcase
    end

    // R6 pulse width: one-shot of 1
    do_cmd(8'h30); do_wr(8'h01); do_wr(8'h00);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    chk("R6 pulse high", irq, 1);
    @(negedge clk);
    chk("R6 pulse low", irq, 0);

    // R2 byte write beats a same-cycle strobe: one-shot 2, strobe lost
    do_wr(8'h02);
    @(negedge clk); din = 8'h00; wr_stb = 1'b1; cnt_en = 1'b1;
    @(negedge clk); wr_stb = 1'b0; cnt_en = 1'b0;
    do_rd(v); chk("R2 write wins lo", v, 2);
    do_rd(v); chk("R2 write wins hi", v, 0);

    // R1 reset mid-sequence clears latch, toggles, error and mode
    do_cmd(8'h34);
    do_cmd(8'h00);
    do_wr(8'h09);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 err cleared", cfg_err, 0);
    do_wr(8'h04); do_wr(8'h00);
    do_rd(v); chk("R1 toggles reset lo", v, 4);
    do_rd(v); chk("R1 toggles reset hi", v, 0);
    do_tick(4);
    chk("R1 one-shot after reset", out_level, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule